// File: doc/BRIEF.md
# Key Deployment Sequencer

This block steers one key deployment job through three phases: preparation, processing and post-processing. Software writes a configuration byte holding a generation mode and a key purpose, then starts the job from idle. The sequencer pauses twice, once after preparation and once after processing, and it waits in each pause for a separate proceed command from software. Each phase has its own completion interrupt. The block latches a pass/fail result and keeps one sticky deployed flag per key type.

The processing phase is a stub. It stays busy for a delay set on an input port, then takes its outcome from a pass/fail input. The cryptographic datapath, the random source and the key storage sit outside the block. Registers are reached through a byte-wide memory-mapped port. Writes take effect at the clock edge and reads are combinational.

Top module: `keydeploy_seq`

## Requirements
- R1: After reset the state code is 0 and the raw interrupts, interrupt enables, result and valid flags are all 0. The `irq` output is low.
- R2: Offset 0x08 reads the state code: 0 idle, 1 load pause, 2 gain pause, 3 busy. A job moves idle → load → busy (processing) → gain → busy (post-processing) → idle.
- R3: At offset 0x00, writing bit 0 starts a job, and only in idle. Writing bit 1 proceeds, and only in the load or gain pause. A command written in any other state changes nothing. Both bits read back as 0.
- R4: After the proceed from load, processing stays busy for `proc_cycles`+1 cycles before it enters gain. After the proceed from gain, post-processing stays busy for POST_LEN+1 cycles (default 3) before it returns to idle.
- R5: Raw interrupt bits at offset 0x14 are sticky. Bit 0 sets on entry to load, bit 1 on entry to gain, and bit 2 on the return to idle after post-processing.
- R6: Writing 1s to offset 0x20 clears the matching raw bits. If a set and a clear of the same bit fall in one cycle, the set wins. Offset 0x18 holds the enables, which reset to 0. Offset 0x1C reads raw AND enable, and `irq` is the OR of that view.
- R7: The configuration byte at offset 0x04 holds the mode in bits [2:0] and the purpose in bits [7:4]. Modes 0–5 are legal and 6–7 are reserved. Purposes 1–4 are legal and all others are reserved. A start with a reserved code leaves the block idle, writes result 0 and raises no interrupt.
- R8: The result at offset 0x0C bit 0 is cleared by an accepted start. When processing ends it is loaded from `proc_pass`, where 1 means success.
- R9: The valid flags sit at offset 0x10. Bit 0 covers the signing key (purpose 1) and bit 1 the storage-encryption key (purposes 2, 3, 4). On return to idle with result 1, the flag for the job's purpose sets and stays set until reset. A failed job sets no flag.
- R10: The purpose is captured at start. A configuration write during a job does not change which valid flag the job sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address (word aligned) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| proc_cycles | input | DLY_W | Processing stub delay |
| proc_pass | input | 1 | Processing stub outcome |
| irq | output | 1 | OR of masked interrupts |

## Verification
Two events can land on the same raw interrupt register in one cycle. One is the processing-done set as the stub finishes. The other is a software clear write. The bench picks a processing delay, counts edges from the proceed write, and places a clear of bits 0 and 1 on exactly the edge where processing completes. It then expects bit 0 cleared and bit 1 set, since the set wins, with the state already in the gain pause.

// File: rtl/keydeploy_seq.sv
module keydeploy_seq #(
  parameter int ADDR_W   = 6,
  parameter int DLY_W    = 8,
  parameter int POST_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [DLY_W-1:0]  proc_cycles,
  input  logic              proc_pass,
  output logic              irq
);
  localparam int WW = ADDR_W - 2;
  localparam logic [WW-1:0] A_CMD = WW'(0), A_CFG = WW'(1), A_STATE = WW'(2),
    A_RES = WW'(3), A_VALID = WW'(4), A_RAW = WW'(5), A_EN = WW'(6),
    A_STAT = WW'(7), A_CLR = WW'(8);

  typedef enum logic [2:0] {PH_IDLE, PH_LOAD, PH_PROC, PH_GAIN, PH_POST} ph_e;

  ph_e              ph_q;
  logic [DLY_W-1:0] cnt_q;
  logic [7:0]       cfg_q;
  logic [2:0]       raw_q, en_q;
  logic             result_q, job_store_q;
  logic [1:0]       valid_q;

  wire [WW-1:0] word = bus_addr[ADDR_W-1:2];
  wire wr_hit    = bus_we && bus_addr[1:0] == 2'b00;
  wire start_req = wr_hit && word == A_CMD && bus_wdata[0];
  wire go_req    = wr_hit && word == A_CMD && bus_wdata[1];
  wire [2:0] mode    = cfg_q[2:0];
  wire [3:0] purpose = cfg_q[7:4];
  wire cfg_ok    = mode <= 3'd5 && purpose >= 4'd1 && purpose <= 4'd4;

  wire start_ok  = ph_q == PH_IDLE && start_req && cfg_ok;
  wire start_bad = ph_q == PH_IDLE && start_req && !cfg_ok;
  wire proc_end  = ph_q == PH_PROC && cnt_q == '0;
  wire post_end  = ph_q == PH_POST && cnt_q == '0;
  wire [2:0] set_bits = {post_end, proc_end, start_ok};
  wire [2:0] clr_bits = (wr_hit && word == A_CLR) ? bus_wdata[2:0] : 3'b000;
  wire [2:0] stat     = raw_q & en_q;

  assign irq = |stat;

  logic [1:0] state_code;
  always_comb begin
    case (ph_q)
      PH_LOAD:         state_code = 2'd1;
      PH_GAIN:         state_code = 2'd2;
      PH_PROC, PH_POST: state_code = 2'd3;
      default:         state_code = 2'd0;
    endcase
  end

  always_comb begin
    case (word)
      A_CFG:   bus_rdata = cfg_q;
      A_STATE: bus_rdata = {6'b0, state_code};
      A_RES:   bus_rdata = {7'b0, result_q};
      A_VALID: bus_rdata = {6'b0, valid_q};
      A_RAW:   bus_rdata = {5'b0, raw_q};
      A_EN:    bus_rdata = {5'b0, en_q};
      A_STAT:  bus_rdata = {5'b0, stat};
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      cnt_q <= '0;
      cfg_q <= '0;
      raw_q <= '0;
      en_q <= '0;
      result_q <= 1'b0;
      job_store_q <= 1'b0;
      valid_q <= '0;
    end else begin
      if (wr_hit && word == A_CFG) cfg_q <= bus_wdata;
      if (wr_hit && word == A_EN)  en_q <= bus_wdata[2:0];
      raw_q <= (raw_q & ~clr_bits) | set_bits;
      case (ph_q)
        PH_IDLE: begin
          if (start_ok) begin
            ph_q <= PH_LOAD;
            result_q <= 1'b0;
            job_store_q <= purpose != 4'd1;
          end else if (start_bad) begin
            result_q <= 1'b0;
          end
        end
        PH_LOAD: if (go_req) begin
          ph_q <= PH_PROC;
          cnt_q <= proc_cycles;
        end
        PH_PROC: begin
          if (proc_end) begin
            ph_q <= PH_GAIN;
            result_q <= proc_pass;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_GAIN: if (go_req) begin
          ph_q <= PH_POST;
          cnt_q <= DLY_W'(POST_LEN);
        end
        PH_POST: begin
          if (post_end) begin
            ph_q <= PH_IDLE;
            if (result_q) valid_q[job_store_q] <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  p_start_enters_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (ph_q == PH_LOAD && raw_q[0]));
  p_reserved_rejected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (ph_q == PH_IDLE && !result_q));
  p_proceed_in_idle_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && go_req && !start_req) |=> ph_q == PH_IDLE);
  p_proc_holds_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PROC && cnt_q != '0) |=> ph_q == PH_PROC);
  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    proc_end |=> raw_q[1]);
  p_valid0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q[0] |=> valid_q[0]);
  p_valid1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q[1] |=> valid_q[1]);
endmodule

// File: tb/keydeploy_seq_tb.sv
`timescale 1ns/1ps
module keydeploy_seq_tb;
  localparam int ADDR_W = 6, DLY_W = 8, POST_LEN = 3;
  localparam int O_CMD = 'h00, O_CFG = 'h04, O_STATE = 'h08, O_RES = 'h0C,
    O_VALID = 'h10, O_RAW = 'h14, O_EN = 'h18, O_STAT = 'h1C, O_CLR = 'h20;

  logic clk = 0, rst_n = 0, bus_we = 0, proc_pass = 1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [DLY_W-1:0] proc_cycles = '0;
  logic irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  keydeploy_seq #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .POST_LEN(POST_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .proc_cycles(proc_cycles),
    .proc_pass(proc_pass), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkrd(input string tag, input int a, input int exp);
    bus_addr = ADDR_W'(a);
    #0.1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic wr(input int a, input int d);
    bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chkrd("R1 state", O_STATE, 0);
    chkrd("R1 raw", O_RAW, 0);
    chkrd("R1 en", O_EN, 0);
    chkrd("R1 result", O_RES, 0);
    chkrd("R1 valid", O_VALID, 0);
    chk("R1 irq", int'(irq), 0);
    chkrd("R3 cmd reads 0", O_CMD, 0);
  endtask

  task automatic t_wrong_cmds;
    wr(O_CMD, 2);
    chkrd("R3 proceed in idle", O_STATE, 0);
    chkrd("R3 no irq raw", O_RAW, 0);
  endtask

  task automatic t_pass_signing;
    proc_cycles = 4; proc_pass = 1;
    wr(O_EN, 7);
    wr(O_CFG, 8'h10);
    wr(O_CMD, 1);
    chkrd("R2 load", O_STATE, 1);
    chkrd("R5 prep raw", O_RAW, 1);
    chk("R6 irq on", int'(irq), 1);
    wr(O_CMD, 1);
    chkrd("R3 start in load", O_STATE, 1);
    wr(O_CLR, 1);
    chkrd("R6 clear", O_RAW, 0);
    wr(O_CMD, 2);
    idle(4);
    chkrd("R4 still busy", O_STATE, 3);
    idle(1);
    chkrd("R2 gain", O_STATE, 2);
    chkrd("R5 proc raw", O_RAW, 2);
    chkrd("R8 pass", O_RES, 1);
    wr(O_CMD, 2);
    idle(POST_LEN);
    chkrd("R4 post busy", O_STATE, 3);
    chkrd("R9 not yet", O_VALID, 0);
    idle(1);
    chkrd("R2 idle", O_STATE, 0);
    chkrd("R5 post raw", O_RAW, 6);
    chkrd("R9 signing valid", O_VALID, 1);
    wr(O_CLR, 7);
  endtask

  task automatic t_reject;
    wr(O_CFG, 8'h16);
    wr(O_CMD, 1);
    chkrd("R7 mode 6 state", O_STATE, 0);
    chkrd("R7 mode 6 result", O_RES, 0);
    wr(O_CFG, 8'h50);
    wr(O_CMD, 1);
    chkrd("R7 purpose 5", O_STATE, 0);
    wr(O_CFG, 8'h00);
    wr(O_CMD, 1);
    chkrd("R7 purpose 0", O_STATE, 0);
    chkrd("R7 no irq", O_RAW, 0);
    chkrd("R7 valid", O_VALID, 1);
  endtask

  task automatic t_fail_job;
    proc_cycles = 1; proc_pass = 0;
    wr(O_CFG, 8'h25);
    wr(O_CMD, 1);
    wr(O_CMD, 2);
    idle(2);
    chkrd("R8 fail result", O_RES, 0);
    wr(O_CMD, 2);
    idle(POST_LEN + 1);
    chkrd("R5 post after fail", O_RAW, 7);
    chkrd("R9 no flag on fail", O_VALID, 1);
    wr(O_CLR, 7);
    proc_pass = 1;
  endtask

  task automatic t_latch_cfg;
    proc_cycles = 0;
    wr(O_CFG, 8'h32);
    wr(O_CMD, 1);
    chkrd("R8 cleared on start", O_RES, 0);
    wr(O_CFG, 8'h10);
    wr(O_CMD, 2);
    idle(1);
    wr(O_CMD, 2);
    idle(POST_LEN + 1);
    chkrd("R10 purpose latched", O_VALID, 3);
    wr(O_CLR, 7);
  endtask

  task automatic t_collision;
    proc_cycles = 2;
    wr(O_CFG, 8'h41);
    wr(O_CMD, 1);
    wr(O_CMD, 2);
    idle(2);
    wr(O_CLR, 3);
    chkrd("R6 set wins", O_RAW, 2);
    chkrd("R6 collision state", O_STATE, 2);
    wr(O_CMD, 2);
    idle(POST_LEN + 1);
    chkrd("R9 purpose 4", O_VALID, 3);
  endtask

  task automatic t_mask;
    wr(O_EN, 0);
    chkrd("R6 stat masked", O_STAT, 0);
    chk("R6 irq masked", int'(irq), 0);
    wr(O_EN, 4);
    chkrd("R6 stat bit2", O_STAT, 4);
    chk("R6 irq bit2", int'(irq), 1);
    wr(O_CLR, 4);
    chkrd("R6 stat cleared", O_STAT, 0);
    chk("R6 irq low", int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    t_reset;
    t_wrong_cmds;
    t_pass_signing;
    t_reject;
    t_fail_job;
    t_latch_cfg;
    t_collision;
    t_mask;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule